// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Control

This block compares two divided pulse trains inside a frequency synthesiser: one from the RF divider chain and one from the reference divider. Both run in the system clock domain. A rising edge on either input sets a correction flip-flop. When both flip-flops are set, a one-cycle reset clears them. The outputs are pump-up and pump-down enables for an external charge pump. Because the two flip-flops always overlap for at least one cycle, there is no dead band around the in-phase point.

A sense bit sets the direction of correction. It also swaps which monitor output carries which divided pulse, so an external detector wired to the monitors follows the same polarity. A two-bit mode code selects one of four behaviours:
- detector on, monitors off;
- detector on, monitors on;
- detector on until lock, then handed to an external detector;
- detector off.

A two-bit gain code passes straight through to the charge pump. While the load strobe is high, the comparator is held clear and the pump is disabled.

Lock is judged once per comparison. The measure is how long one correction output stays high alone before the AND of the two outputs asserts. A saturating counter filters these results: a run of good comparisons raises lock, and a shorter run of bad ones drops it.

Top module: `pfd_lock_ctrl`

## Requirements
- R1: When both divided inputs rise in the same cycle, pump_up and pump_dn are each high for exactly one cycle. The first clock edge registers the edges and the next edge clears them.
- R2: While strobe is 1: pump_en is 0, rising edges on the inputs are ignored (no pump or monitor pulse), and the correction flip-flops are clear. pump_en returns to 1 in the cycle strobe falls, when the mode permits it.
- R3: If the leading input rises d cycles before the lagging one, the leading-side output is high for d+1 cycles and the lagging-side output for 1 cycle. Both then clear together.
- R4: With sense = 1, an RF rising edge drives pump_dn and a reference rising edge drives pump_up. With sense = 0 the roles are exchanged.
- R5: With sense = 1, mon_a carries the RF edge pulse and mon_b the reference edge pulse. With sense = 0 they are swapped. Each monitor pulse is one cycle wide and appears one cycle after the input rises.
- R6: Mode 00 keeps the detector active and holds both monitors low. Mode 01 keeps the detector active and the monitors running.
- R7: Mode 11 holds pump_en, pump_up and pump_dn low, while the monitors keep running.
- R8: Mode 10 behaves like mode 01 while lock is 0. While lock is 1, it holds pump_en low.
- R9: A comparison is good when the single-sided interval before the overlap is at most PHASE_TOL cycles (default 2). lock rises after LOCK_CYCLES consecutive good comparisons (default 6). Any bad comparison restarts the count.
- R10: Once locked, lock falls after max(1, LOCK_CYCLES/3) consecutive bad comparisons (default 2). A good comparison restarts that count.
- R11: gain_code follows gain_sel without delay. The codes map to pump current multipliers: 00 = 1.0, 01 = 1.5, 10 = 2.5, 11 = 4.0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rf_pulse | input | 1 | Divided RF pulse; rising edge is used |
| ref_pulse | input | 1 | Divided reference pulse; rising edge is used |
| sense | input | 1 | Comparator and monitor polarity |
| pd_state | input | 2 | Detector and monitor mode |
| gain_sel | input | 2 | Pump current multiplier code |
| strobe | input | 1 | Load strobe; holds the comparator clear |
| pump_up | output | 1 | Source-direction pump enable |
| pump_dn | output | 1 | Sink-direction pump enable |
| pump_en | output | 1 | Pump permitted by mode and strobe |
| gain_code | output | 2 | Multiplier code to the pump |
| lock | output | 1 | Filtered lock indication |
| mon_a | output | 1 | Monitor pulse, RF when sense = 1 |
| mon_b | output | 1 | Monitor pulse, reference when sense = 1 |

## Verification
The pulse inputs are plain level pins with no valid/ready handshake. The block samples every cycle and cannot apply back-pressure, so the assertions assume each input rising edge lasts at least one clock cycle. They also assume no new edge arrives in the cycle the overlap reset clears the flip-flops, because that reset takes priority. The stimulus drives every pulse high for exactly one cycle on the falling clock edge. It waits several idle cycles after each comparison before starting the next, so no edge ever meets a reset cycle. Mode, sense and strobe change only between comparisons, so the monitor and pump gating assertions always see a settled mode.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {
    PD_ON_QUIET = 2'b00,
    PD_ON_MON   = 2'b01,
    PD_HANDOFF  = 2'b10,
    PD_OFF      = 2'b11
  } pd_mode_e;
endpackage

// File: rtl/pfd_edge_sense.sv
module pfd_edge_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic rf_pulse,
  input  logic ref_pulse,
  input  logic sense,
  input  logic strobe,
  output logic rf_evt,
  output logic ref_evt,
  output logic up_set,
  output logic dn_set
);
  logic rf_q, ref_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf_q  <= 1'b0;
      ref_q <= 1'b0;
    end else begin
      rf_q  <= rf_pulse;
      ref_q <= ref_pulse;
    end
  end

  // rising edges, suppressed while the strobe holds the comparator
  assign rf_evt  = rf_pulse  & ~rf_q  & ~strobe;
  assign ref_evt = ref_pulse & ~ref_q & ~strobe;

  // sense = 1: RF leading must sink (down)
  assign up_set = sense ? ref_evt : rf_evt;
  assign dn_set = sense ? rf_evt  : ref_evt;
endmodule

// File: rtl/pfd_core.sv
module pfd_core #(
  parameter int PHASE_TOL = 2,
  parameter int WIDTH_W   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic up_set,
  input  logic dn_set,
  output logic up_q,
  output logic dn_q,
  output logic cmp_valid,
  output logic cmp_good
);
  localparam logic [WIDTH_W-1:0] WIDTH_MAX = {WIDTH_W{1'b1}};
  localparam logic [WIDTH_W-1:0] TOL_V     = WIDTH_W'(PHASE_TOL);

  logic             overlap;
  logic [WIDTH_W-1:0] single_cnt;

  assign overlap = up_q & dn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (strobe || overlap) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_q | up_set;
      dn_q <= dn_q | dn_set;
    end
  end

  // cycles spent with exactly one side active before the overlap
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      single_cnt <= '0;
    end else if (strobe || overlap) begin
      single_cnt <= '0;
    end else if ((up_q ^ dn_q) && single_cnt != WIDTH_MAX) begin
      single_cnt <= single_cnt + 1'b1;
    end
  end

  assign cmp_valid = overlap & ~strobe;
  assign cmp_good  = (single_cnt <= TOL_V);

  assert_pulse_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && dn_q) |=> (!up_q && !dn_q));
endmodule

// File: rtl/pfd_lock_filter.sv
module pfd_lock_filter #(
  parameter int LOCK_CYCLES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_valid,
  input  logic cmp_good,
  output logic lock
);
  localparam int UNLOCK_CYCLES = (LOCK_CYCLES / 3 < 1) ? 1 : LOCK_CYCLES / 3;
  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOCK_LAST   = CNT_W'(LOCK_CYCLES - 1);
  localparam logic [CNT_W-1:0] UNLOCK_LAST = CNT_W'(UNLOCK_CYCLES - 1);

  logic [CNT_W-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock    <= 1'b0;
      run_cnt <= '0;
    end else if (cmp_valid) begin
      if (!lock) begin
        if (!cmp_good) begin
          run_cnt <= '0;
        end else if (run_cnt == LOCK_LAST) begin
          lock    <= 1'b1;
          run_cnt <= '0;
        end else begin
          run_cnt <= run_cnt + 1'b1;
        end
      end else begin
        if (cmp_good) begin
          run_cnt <= '0;
        end else if (run_cnt == UNLOCK_LAST) begin
          lock    <= 1'b0;
          run_cnt <= '0;
        end else begin
          run_cnt <= run_cnt + 1'b1;
        end
      end
    end
  end

  assert_lock_moves_on_compare_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lock != $past(lock)) |-> $past(cmp_valid));
endmodule

// File: rtl/pfd_lock_ctrl.sv
module pfd_lock_ctrl
  import pfd_pkg::*;
#(
  parameter int PHASE_TOL   = 2,
  parameter int LOCK_CYCLES = 6,
  parameter int WIDTH_W     = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rf_pulse,
  input  logic       ref_pulse,
  input  logic       sense,
  input  logic [1:0] pd_state,
  input  logic [1:0] gain_sel,
  input  logic       strobe,
  output logic       pump_up,
  output logic       pump_dn,
  output logic       pump_en,
  output logic [1:0] gain_code,
  output logic       lock,
  output logic       mon_a,
  output logic       mon_b
);
  logic rf_evt, ref_evt, up_set, dn_set;
  logic up_q, dn_q, cmp_valid, cmp_good;
  logic det_active, mon_on;
  pd_mode_e mode;

  assign mode = pd_mode_e'(pd_state);

  pfd_edge_sense u_edge (
    .clk(clk), .rst_n(rst_n), .rf_pulse(rf_pulse), .ref_pulse(ref_pulse),
    .sense(sense), .strobe(strobe), .rf_evt(rf_evt), .ref_evt(ref_evt),
    .up_set(up_set), .dn_set(dn_set)
  );

  pfd_core #(.PHASE_TOL(PHASE_TOL), .WIDTH_W(WIDTH_W)) u_core (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .up_set(up_set),
    .dn_set(dn_set), .up_q(up_q), .dn_q(dn_q), .cmp_valid(cmp_valid),
    .cmp_good(cmp_good)
  );

  pfd_lock_filter #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_good(cmp_good),
    .lock(lock)
  );

  always_comb begin
    unique case (mode)
      PD_ON_QUIET: begin det_active = 1'b1;  mon_on = 1'b0; end
      PD_ON_MON:   begin det_active = 1'b1;  mon_on = 1'b1; end
      PD_HANDOFF:  begin det_active = ~lock; mon_on = 1'b1; end
      default:     begin det_active = 1'b0;  mon_on = 1'b1; end
    endcase
  end

  assign pump_en   = det_active & ~strobe;
  assign pump_up   = up_q & pump_en;
  assign pump_dn   = dn_q & pump_en;
  assign gain_code = gain_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mon_a <= 1'b0;
      mon_b <= 1'b0;
    end else begin
      mon_a <= mon_on & (sense ? rf_evt  : ref_evt);
      mon_b <= mon_on & (sense ? ref_evt : rf_evt);
    end
  end

  assert_strobe_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && $past(strobe)) |-> (!up_q && !dn_q && !pump_en));

  assert_quiet_monitors_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pd_state) == 2'b00) |-> (!mon_a && !mon_b));

  assert_off_no_pump_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_state == 2'b11) |-> (!pump_up && !pump_dn));

  assert_handoff_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_state == 2'b10 && lock) |-> !pump_en);
endmodule

// File: tb/pfd_lock_ctrl_bench.sv
`timescale 1ns/1ps
module pfd_lock_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rf_pulse = 1'b0, ref_pulse = 1'b0, sense = 1'b1, strobe = 1'b1;
  logic [1:0] pd_state = 2'b01, gain_sel = 2'b00;
  logic pump_up, pump_dn, pump_en, lock, mon_a, mon_b;
  logic [1:0] gain_code;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pfd_lock_ctrl u_pfd_lock_ctrl (
    .clk(clk), .rst_n(rst_n), .rf_pulse(rf_pulse), .ref_pulse(ref_pulse),
    .sense(sense), .pd_state(pd_state), .gain_sel(gain_sel), .strobe(strobe),
    .pump_up(pump_up), .pump_dn(pump_dn), .pump_en(pump_en),
    .gain_code(gain_code), .lock(lock), .mon_a(mon_a), .mon_b(mon_b)
  );

  typedef struct packed {
    int sense; int state; int rf_t; int ref_t;
    int up_w; int dn_w; int ma_t; int mb_t;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VEC [NVEC] = '{
    '{1, 1, 0, 2, 1, 3, 1, 3},
    '{1, 1, 3, 0, 4, 1, 4, 1},
    '{0, 1, 0, 2, 3, 1, 3, 1},
    '{0, 1, 1, 0, 1, 2, 1, 2},
    '{1, 0, 0, 0, 1, 1, -1, -1},
    '{1, 3, 0, 2, 0, 0, 1, 3},
    '{0, 0, 4, 0, 1, 5, -1, -1},
    '{1, 1, 0, 0, 1, 1, 1, 1}
  };

  int up_w, dn_w, ma_t, mb_t;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // iteration i samples, then drives inputs for the next rising edge
  task automatic run_cmp(input int rf_t, input int ref_t);
    int win;
    win = ((rf_t > ref_t) ? rf_t : ref_t) + 6;
    up_w = 0; dn_w = 0; ma_t = -1; mb_t = -1;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (pump_up) up_w++;
      if (pump_dn) dn_w++;
      if (mon_a && ma_t < 0) ma_t = i;
      if (mon_b && mb_t < 0) mb_t = i;
      rf_pulse  = (i == rf_t);
      ref_pulse = (i == ref_t);
    end
    @(negedge clk);
    rf_pulse = 1'b0;
    ref_pulse = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state with strobe held high (R2)
    chk("R2 reset pump_en", pump_en, 0);
    chk("R2 reset pump_up", pump_up, 0);
    chk("R9 reset lock", lock, 0);
    chk("R5 reset mon_a", mon_a, 0);

    // strobe high: edges ignored (R2)
    run_cmp(0, 2);
    chk("R2 strobe up width", up_w, 0);
    chk("R2 strobe dn width", dn_w, 0);
    chk("R2 strobe mon", ma_t, -1);
    strobe = 1'b0;
    #0.1;
    chk("R2 pump_en after strobe", pump_en, 1);
    @(negedge clk);
    chk("R2 no residual up", pump_up, 0);
    chk("R2 no residual dn", pump_dn, 0);

    // vector table: R1 R3 R4 R5 R6 R7
    for (int k = 0; k < NVEC; k++) begin
      sense    = VEC[k].sense[0];
      pd_state = VEC[k].state[1:0];
      run_cmp(VEC[k].rf_t, VEC[k].ref_t);
      chk($sformatf("R3/R4 vec%0d up width", k), up_w, VEC[k].up_w);
      chk($sformatf("R3/R4 vec%0d dn width", k), dn_w, VEC[k].dn_w);
      chk($sformatf("R5/R6 vec%0d mon_a time", k), ma_t, VEC[k].ma_t);
      chk($sformatf("R5/R6 vec%0d mon_b time", k), mb_t, VEC[k].mb_t);
    end
    // R1 in-phase explicit, R7 pump_en in mode 11
    sense = 1'b1; pd_state = 2'b11;
    #0.1;
    chk("R7 pump_en mode 11", pump_en, 0);
    pd_state = 2'b01;
    run_cmp(0, 0);
    chk("R1 in-phase up one cycle", up_w, 1);
    chk("R1 in-phase dn one cycle", dn_w, 1);

    // lock acquisition R9: restart with a bad comparison (d=3 > tol)
    run_cmp(0, 3);
    chk("R9 unlocked after bad", lock, 0);
    for (int n = 0; n < 4; n++) run_cmp(0, 0);
    run_cmp(0, 2);   // d equals tolerance: good, fifth
    chk("R9 no lock after five good", lock, 0);
    run_cmp(2, 0);
    chk("R9 lock after six good", lock, 1);

    // unlock R10
    run_cmp(0, 3);
    chk("R10 lock kept after one bad", lock, 1);
    run_cmp(0, 0);
    run_cmp(0, 4);
    chk("R10 good restarts bad count", lock, 1);
    run_cmp(3, 0);
    chk("R10 lock lost after two bad", lock, 0);

    // handoff mode R8
    for (int n = 0; n < 6; n++) run_cmp(0, 0);
    chk("R8 locked before handoff", lock, 1);
    pd_state = 2'b10;
    #0.1;
    chk("R8 pump_en off when locked", pump_en, 0);
    run_cmp(0, 1);
    chk("R8 no pump while locked", up_w + dn_w, 0);
    chk("R8 monitors run while locked", ma_t, 1);
    run_cmp(0, 3);
    run_cmp(0, 3);
    chk("R8 lock dropped", lock, 0);
    chk("R8 pump_en back", pump_en, 1);
    run_cmp(0, 2);
    chk("R8 pump dn active when unlocked", dn_w, 3);

    // gain passthrough R11
    for (int g = 0; g < 4; g++) begin
      gain_sel = 2'(g);
      #0.1;
      chk("R11 gain_code", int'(gain_code), g);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule